// File: doc/BRIEF.md
# 16-to-32 Bit Slave-to-Master Cycle Combiner

This bridge core sits between a narrow bus, where it acts as a 16-bit slave, and a wide bus, where it is the only 32-bit master, so it never has to arbitrate. Each 32-bit master transfer is built from a pair of 16-bit slave accesses. The combined master address has two sources. Its upper twelve bits come from a write-only offset register. Slave address bits 19..2 pass straight through, and bits 1..0 are forced to zero because only aligned longword transfers are issued.

Writes and reads are split across the two halves in opposite ways. For a write, the first half only captures the address and the upper data word. The second half captures the lower word and runs the master write. That second half is not acknowledged until the master transfer has finished. For a read, the first half runs the whole master read. It returns the upper word and keeps the lower word on chip. The second half then returns the kept lower word and does not touch the master bus.

A half-tracking bit records which half comes next. If the direction changes between halves, the half in progress is dropped. Two sticky indicator outputs show that the offset register has been written and that a master data transfer has taken place.

Top module: `slv16_mst32_bridge`

## Requirements
- R1: The block answers a slave access only when address bits 23..21 equal the parameter BASE_TAG (default 3'b010) and the modifier code is one of 0x39, 0x3A, 0x3D or 0x3E. Any other access gets no acknowledge and starts no master activity.
- R2: A slave write with address bit 20 set loads data bits 15..4 into the offset register, which supplies master address bits 31..20. Data bits 3..0 are ignored. It completes in one slave cycle with no master activity. A slave read of that address returns 0x0000 and leaves the offset unchanged.
- R3: A first-half data write (address bit 20 clear) is acknowledged. It captures address bits 19..2 and the write data as the upper word, and starts no master activity.
- R4: A second-half data write starts one master write. The address is {offset, first-half address bits 19..2, 2'b00} and the data is {first-half word, second-half word}. m_as is high for exactly one cycle, followed by m_ds.
- R5: The second-half write is acknowledged only after m_ack has ended the master transfer, and never while m_ds is high.
- R6: A first-half data read starts one master read at {offset, address bits 19..2, 2'b00}. It returns m_rdata[31:16] on s_rdata together with an acknowledge that comes after m_ack.
- R7: A second-half data read returns the m_rdata[15:0] kept from the preceding master read and starts no master activity.
- R8: After reset, and whenever the direction differs from the pending first half, a data access is treated as a first half.
- R9: led_off is 0 after reset and goes high and stays high after an offset write. led_act is 0 after reset and goes high and stays high from the first master transfer on.
- R10: s_ack is a single-cycle pulse. After it, no new access is accepted until s_req has been low for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req | input | 1 | Slave access request, held until acknowledged |
| s_we | input | 1 | Slave direction, 1 = write |
| s_addr | input | 23 | Slave address bits 23..1 |
| s_am | input | 6 | Slave address modifier code |
| s_wdata | input | 16 | Slave write data |
| s_rdata | output | 16 | Slave read data, valid with s_ack |
| s_ack | output | 1 | Slave acknowledge pulse |
| m_as | output | 1 | Master address strobe (one cycle) |
| m_ds | output | 1 | Master data strobe, held until m_ack |
| m_we | output | 1 | Master direction, 1 = write |
| m_addr | output | 32 | Master longword address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ack |
| m_ack | input | 1 | Master transfer complete |
| led_off | output | 1 | Sticky: offset register written |
| led_act | output | 1 | Sticky: master data transfer seen |

## Verification
The hardest case to reach is a direction change in the middle of a pair. The pending half sits in internal state that the ports do not show directly, so the stimulus has to expose it. It does this by abandoning a write first half with a read, and then starting a fresh write. The abandoned read must run a master read, and the new write pair must carry the newer first-half address and word. A second case needing care is the acknowledge order. The bench's master responder stalls before it answers and records the cycle of its m_ack, and the bench confirms that the slave acknowledge only ever lands after that cycle.

// File: rtl/s2m_pkg.sv
// Shared types and helpers for the 16-to-32 cycle combiner.
// Assumes a 6-bit modifier code and a fixed split of the master address at bit 20.
package s2m_pkg;
    localparam int AM_W  = 6;
    localparam int SPLIT = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MADDR,
        ST_MDATA,
        ST_ACK,
        ST_REL
    } bst_t;

    // True for the modifier codes the slave side accepts.
    function automatic logic am_accept(input logic [AM_W-1:0] am);
        return (am == 6'h39) || (am == 6'h3A) || (am == 6'h3D) || (am == 6'h3E);
    endfunction
endpackage

// File: rtl/s2m_decode.sv
// Slave-side select decode. Compares the upper address tag with BASE_TAG,
// checks the modifier code and splits register from data space on bit 20.
// Assumes SA_W > 21; purely combinational.
module s2m_decode
    import s2m_pkg::*;
#(
    parameter int SA_W = 24,
    parameter logic [SA_W-22:0] BASE_TAG = '0
) (
    input  logic             s_req,
    input  logic [SA_W-1:20] s_addr_hi,
    input  logic [AM_W-1:0]  s_am,
    output logic             sel_reg,
    output logic             sel_data
);
    logic hit;

    // Address tag and modifier qualify the request.
    always_comb begin
        hit      = s_req && (s_addr_hi[SA_W-1:21] == BASE_TAG) && am_accept(s_am);
        sel_reg  = hit && s_addr_hi[SPLIT];
        sel_data = hit && !s_addr_hi[SPLIT];
    end
endmodule

// File: rtl/s2m_ctrl.sv
// Cycle sequencer. Tracks which half of a pair comes next and the direction
// of the pending first half, runs the master address and data phases, and
// produces the slave acknowledge pulse. Assumes the slave holds s_req until
// s_ack and drops it afterwards.
module s2m_ctrl
    import s2m_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_req,
    input  logic s_we,
    input  logic sel_reg,
    input  logic sel_data,
    input  logic m_ack,
    output logic ld_off,
    output logic ld_first,
    output logic start_wr,
    output logic start_rd,
    output logic ld_rd,
    output logic rd_lo,
    output logic rd_zero,
    output logic m_as,
    output logic m_ds,
    output logic m_we,
    output logic s_ack
);
    bst_t st_q, st_d;
    logic second_q, second_d;
    logic dirwe_q, dirwe_d;
    logic mwe_q, mwe_d;
    logic first_half;

    // Next state, half tracking and datapath strobes.
    always_comb begin
        st_d      = st_q;
        second_d  = second_q;
        dirwe_d   = dirwe_q;
        mwe_d     = mwe_q;
        ld_off    = 1'b0;
        ld_first  = 1'b0;
        start_wr  = 1'b0;
        start_rd  = 1'b0;
        ld_rd     = 1'b0;
        rd_lo     = 1'b0;
        rd_zero   = 1'b0;
        first_half = !second_q || (dirwe_q != s_we);
        unique case (st_q)
            ST_IDLE: begin
                if (sel_reg) begin
                    ld_off  = s_we;
                    rd_zero = !s_we;
                    st_d    = ST_ACK;
                end else if (sel_data) begin
                    if (s_we && first_half) begin
                        ld_first = 1'b1;
                        second_d = 1'b1;
                        dirwe_d  = 1'b1;
                        st_d     = ST_ACK;
                    end else if (s_we) begin
                        start_wr = 1'b1;
                        second_d = 1'b0;
                        mwe_d    = 1'b1;
                        st_d     = ST_MADDR;
                    end else if (first_half) begin
                        start_rd = 1'b1;
                        second_d = 1'b1;
                        dirwe_d  = 1'b0;
                        mwe_d    = 1'b0;
                        st_d     = ST_MADDR;
                    end else begin
                        rd_lo    = 1'b1;
                        second_d = 1'b0;
                        st_d     = ST_ACK;
                    end
                end
            end
            ST_MADDR: st_d = ST_MDATA;
            ST_MDATA: begin
                if (m_ack) begin
                    ld_rd = !mwe_q;
                    st_d  = ST_ACK;
                end
            end
            ST_ACK: st_d = ST_REL;
            ST_REL: begin
                if (!s_req) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            second_q <= 1'b0;
            dirwe_q  <= 1'b0;
            mwe_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            second_q <= second_d;
            dirwe_q  <= dirwe_d;
            mwe_q    <= mwe_d;
        end
    end

    // Bus strobes decoded from state.
    always_comb begin
        m_as  = (st_q == ST_MADDR);
        m_ds  = (st_q == ST_MDATA);
        m_we  = mwe_q;
        s_ack = (st_q == ST_ACK);
    end
endmodule

// File: rtl/s2m_store.sv
// Datapath storage: offset register, first-half address latch, upper and
// lower data words, master address, slave read data and the sticky
// indicators. All loads are strobed by the sequencer.
module s2m_store #(
    parameter int MA_W = 32,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [19:2]     s_addr_mid,
    input  logic [DW-1:0]   s_wdata,
    input  logic [MA_W-1:0] m_rdata,
    input  logic            ld_off,
    input  logic            ld_first,
    input  logic            start_wr,
    input  logic            start_rd,
    input  logic            ld_rd,
    input  logic            rd_lo,
    input  logic            rd_zero,
    output logic [MA_W-1:0] m_addr,
    output logic [MA_W-1:0] m_wdata,
    output logic [DW-1:0]   s_rdata,
    output logic            led_off,
    output logic            led_act
);
    localparam int OFF_W = MA_W - 20;

    logic [OFF_W-1:0] off_q;
    logic [19:2]      alat_q;
    logic [DW-1:0]    hi_q;
    logic [DW-1:0]    lo_q;
    logic [MA_W-1:0]  maddr_q;
    logic [DW-1:0]    rdat_q;
    logic             ledo_q;
    logic             leda_q;

    // Offset register and sticky indicators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            ledo_q <= 1'b0;
            leda_q <= 1'b0;
        end else begin
            if (ld_off) begin
                off_q  <= s_wdata[DW-1 -: OFF_W];
                ledo_q <= 1'b1;
            end
            if (start_wr || start_rd) leda_q <= 1'b1;
        end
    end

    // First-half latch, data words and master address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alat_q  <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            maddr_q <= '0;
        end else begin
            if (ld_first) begin
                alat_q <= s_addr_mid;
                hi_q   <= s_wdata;
            end
            if (start_wr) begin
                lo_q    <= s_wdata;
                maddr_q <= {off_q, alat_q, 2'b00};
            end
            if (start_rd) maddr_q <= {off_q, s_addr_mid, 2'b00};
            if (ld_rd)    lo_q    <= m_rdata[DW-1:0];
        end
    end

    // Slave read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdat_q <= '0;
        else if (ld_rd)   rdat_q <= m_rdata[MA_W-1 -: DW];
        else if (rd_lo)   rdat_q <= lo_q;
        else if (rd_zero) rdat_q <= '0;
    end

    // Output mapping.
    always_comb begin
        m_addr  = maddr_q;
        m_wdata = {hi_q, lo_q};
        s_rdata = rdat_q;
        led_off = ledo_q;
        led_act = leda_q;
    end
endmodule

// File: rtl/slv16_mst32_bridge.sv
// Top of the 16-bit slave / 32-bit master cycle combiner. Ties decode,
// sequencer and storage together. Assumes it is the sole master on the
// wide bus and that the narrow-bus requester holds s_req until s_ack.
module slv16_mst32_bridge
    import s2m_pkg::*;
#(
    parameter int SA_W = 24,
    parameter logic [SA_W-22:0] BASE_TAG = 3'b010,
    parameter int MA_W = 32,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s_req,
    input  logic            s_we,
    input  logic [SA_W-1:1] s_addr,
    input  logic [AM_W-1:0] s_am,
    input  logic [DW-1:0]   s_wdata,
    output logic [DW-1:0]   s_rdata,
    output logic            s_ack,
    output logic            m_as,
    output logic            m_ds,
    output logic            m_we,
    output logic [MA_W-1:0] m_addr,
    output logic [MA_W-1:0] m_wdata,
    input  logic [MA_W-1:0] m_rdata,
    input  logic            m_ack,
    output logic            led_off,
    output logic            led_act
);
    logic sel_reg, sel_data;
    logic ld_off, ld_first, start_wr, start_rd, ld_rd, rd_lo, rd_zero;
    logic unused_a1;

    assign unused_a1 = s_addr[1];

    s2m_decode #(.SA_W(SA_W), .BASE_TAG(BASE_TAG)) u_dec (
        .s_req    (s_req),
        .s_addr_hi(s_addr[SA_W-1:20]),
        .s_am     (s_am),
        .sel_reg  (sel_reg),
        .sel_data (sel_data)
    );

    s2m_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_req   (s_req),
        .s_we    (s_we),
        .sel_reg (sel_reg),
        .sel_data(sel_data),
        .m_ack   (m_ack),
        .ld_off  (ld_off),
        .ld_first(ld_first),
        .start_wr(start_wr),
        .start_rd(start_rd),
        .ld_rd   (ld_rd),
        .rd_lo   (rd_lo),
        .rd_zero (rd_zero),
        .m_as    (m_as),
        .m_ds    (m_ds),
        .m_we    (m_we),
        .s_ack   (s_ack)
    );

    s2m_store #(.MA_W(MA_W), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_addr_mid(s_addr[19:2]),
        .s_wdata   (s_wdata),
        .m_rdata   (m_rdata),
        .ld_off    (ld_off),
        .ld_first  (ld_first),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .ld_rd     (ld_rd),
        .rd_lo     (rd_lo),
        .rd_zero   (rd_zero),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .s_rdata   (s_rdata),
        .led_off   (led_off),
        .led_act   (led_act)
    );
endmodule

// File: rtl/s2m_checker.sv
// Protocol checker for the combiner, bound to the top module.
// Watches only ports; every property is disabled during reset.
module s2m_checker #(
    parameter int MA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_req,
    input logic            s_ack,
    input logic            m_as,
    input logic            m_ds,
    input logic            m_ack,
    input logic [MA_W-1:0] m_addr,
    input logic            led_off,
    input logic            led_act
);
    // R10: acknowledge is a single-cycle pulse.
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |=> !s_ack);

    // R4: address strobe lasts one cycle and is followed by the data strobe.
    p_as_then_ds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_as |=> (m_ds && !m_as));

    // R4: master address is longword aligned.
    p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_as |-> (m_addr[1:0] == 2'b00));

    // R5: no slave acknowledge while the master transfer is open.
    p_no_ack_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> !m_ds);

    // R5: an unanswered data phase keeps the slave waiting.
    p_wait_mack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ds && !m_ack) |=> (m_ds && !s_ack));

    // R1: a master transfer only begins while a slave request is present.
    p_as_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_as |-> s_req);

    // R9: indicators are sticky.
    p_led_off_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        led_off |=> led_off);
    p_led_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_ds |-> led_act);
endmodule

bind slv16_mst32_bridge s2m_checker #(.MA_W(MA_W)) u_s2m_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_req  (s_req),
    .s_ack  (s_ack),
    .m_as   (m_as),
    .m_ds   (m_ds),
    .m_ack  (m_ack),
    .m_addr (m_addr),
    .led_off(led_off),
    .led_act(led_act)
);

// File: tb/slv16_mst32_bridge_bench.sv
// Scoreboard bench: slave tasks push expected master transfers, a monitor
// pops and compares them; a responder answers the master bus with latency.
module slv16_mst32_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic        s_we = 1'b0;
    logic [23:1] s_addr = '0;
    logic [5:0]  s_am = '0;
    logic [15:0] s_wdata = '0;
    logic [15:0] s_rdata;
    logic        s_ack;
    logic        m_as, m_ds, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [31:0] m_rdata = '0;
    logic        m_ack = 1'b0;
    logic        led_off, led_act;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int mack_cyc = 0;
    int mcount = 0;

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
    } mexp_t;
    mexp_t q[$];
    mexp_t cur;
    logic  data_pending = 1'b0;

    always #10 clk = ~clk;

    slv16_mst32_bridge u_slv16_mst32_bridge (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_am(s_am), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack),
        .m_as(m_as), .m_ds(m_ds), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .led_off(led_off), .led_act(led_act)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rmem(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[31:16]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic expect_m(input logic [31:0] a, input logic we, input logic [31:0] d);
        mexp_t e;
        e.addr = a; e.we = we; e.data = d;
        q.push_back(e);
    endtask

    // Master responder: answers each data phase after three cycles.
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (m_ack) begin
                m_ack = 1'b0;
                wait_n = 0;
            end else if (m_ds) begin
                wait_n++;
                if (wait_n == 3) begin
                    m_rdata  = rmem(m_addr);
                    m_ack    = 1'b1;
                    mack_cyc = cyc;
                end
            end
        end
    end

    // Monitor: pops the expected transfer at each address strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && data_pending && m_ds) begin
                data_pending = 1'b0;
                if (cur.we) chk("R4 master write data", m_wdata, cur.data);
            end
            if (rst_n && m_as) begin
                mcount++;
                if (q.size() == 0) begin
                    chk("R1 unexpected master transfer", m_addr, 32'hFFFF_FFFF);
                end else begin
                    cur = q.pop_front();
                    chk("R4/R6 master address", m_addr, cur.addr);
                    chk("R4/R6 master direction", {31'd0, m_we}, {31'd0, cur.we});
                    data_pending = 1'b1;
                end
            end
        end
    end

    task automatic slv_cyc(input logic we, input logic [23:0] a, input logic [5:0] am,
                           input logic [15:0] wd, output logic [15:0] rd,
                           output logic ok, output int ack_at);
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = a[23:1]; s_am = am; s_wdata = wd;
        ok = 1'b0; rd = '0; ack_at = 0;
        for (int i = 0; i < 40 && !ok; i++) begin
            @(negedge clk);
            if (s_ack) begin
                ok = 1'b1; rd = s_rdata; ack_at = cyc;
            end
        end
        s_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic ok;
        int ack_at, mc;
        logic [11:0] off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset s_ack", {31'd0, s_ack}, 0);
        chk("reset m_as", {31'd0, m_as}, 0);
        chk("reset m_ds", {31'd0, m_ds}, 0);
        chk("R9 reset led_off", {31'd0, led_off}, 0);
        chk("R9 reset led_act", {31'd0, led_act}, 0);

        // R2: offset write, no master activity
        mc = mcount;
        slv_cyc(1'b1, 24'h50_0000, 6'h39, 16'hF00F, rd, ok, ack_at);
        off = 12'hF00;
        chk("R2 offset write acked", {31'd0, ok}, 1);
        chk("R2 offset write no master", mcount, mc);
        chk("R9 led_off set", {31'd0, led_off}, 1);
        chk("R9 led_act still low", {31'd0, led_act}, 0);

        // R3/R4/R5: write pair
        slv_cyc(1'b1, 24'h41_2344, 6'h3D, 16'h1234, rd, ok, ack_at);
        chk("R3 first write acked", {31'd0, ok}, 1);
        chk("R3 first write no master", mcount, mc);
        expect_m({off, 20'h12344}, 1'b1, 32'h1234_5678);
        slv_cyc(1'b1, 24'h41_2346, 6'h3D, 16'h5678, rd, ok, ack_at);
        chk("R4 second write acked", {31'd0, ok}, 1);
        chk("R4 second write one master", mcount, mc + 1);
        chk("R5 ack after m_ack", {31'd0, ack_at > mack_cyc}, 1);
        chk("R9 led_act set", {31'd0, led_act}, 1);

        // R6/R7: read pair
        mc = mcount;
        expect_m({off, 20'hABCD0}, 1'b0, 32'h0);
        slv_cyc(1'b0, 24'h4A_BCD0, 6'h3A, 16'h0, rd, ok, ack_at);
        chk("R6 first read acked", {31'd0, ok}, 1);
        chk("R6 first read upper word", {16'd0, rd}, {16'd0, rmem({off, 20'hABCD0})} >> 16);
        chk("R6 ack after m_ack", {31'd0, ack_at > mack_cyc}, 1);
        slv_cyc(1'b0, 24'h4A_BCD2, 6'h3A, 16'h0, rd, ok, ack_at);
        chk("R7 second read lower word", {16'd0, rd}, {16'd0, rmem({off, 20'hABCD0}) & 32'hFFFF});
        chk("R7 second read no master", mcount, mc + 1);

        // R2: modifier 0x3E offset write, read back returns zero
        slv_cyc(1'b1, 24'h50_0000, 6'h3E, 16'h123F, rd, ok, ack_at);
        off = 12'h123;
        mc = mcount;
        slv_cyc(1'b0, 24'h50_0000, 6'h39, 16'h0, rd, ok, ack_at);
        chk("R2 offset read acked", {31'd0, ok}, 1);
        chk("R2 offset read zero", {16'd0, rd}, 0);
        chk("R2 offset read no master", mcount, mc);
        expect_m({off, 20'h00008}, 1'b0, 32'h0);
        slv_cyc(1'b0, 24'h40_0008, 6'h39, 16'h0, rd, ok, ack_at);
        chk("R2 offset kept after read", {16'd0, rd}, {16'd0, rmem({off, 20'h00008})} >> 16);
        slv_cyc(1'b0, 24'h40_000A, 6'h39, 16'h0, rd, ok, ack_at);

        // R1: rejected modifier and rejected tag
        mc = mcount;
        slv_cyc(1'b1, 24'h40_0010, 6'h09, 16'h7777, rd, ok, ack_at);
        chk("R1 bad modifier no ack", {31'd0, ok}, 0);
        slv_cyc(1'b1, 24'h60_0010, 6'h39, 16'h7777, rd, ok, ack_at);
        chk("R1 bad tag no ack", {31'd0, ok}, 0);
        slv_cyc(1'b1, 24'h70_0000, 6'h39, 16'hEEEE, rd, ok, ack_at);
        chk("R1 bad tag offset no ack", {31'd0, ok}, 0);
        chk("R1 rejected no master", mcount, mc);

        // R8: direction change abandons a write first half
        slv_cyc(1'b1, 24'h40_0020, 6'h39, 16'hAAAA, rd, ok, ack_at);
        chk("R8 write first no master", mcount, mc);
        expect_m({off, 20'h00040}, 1'b0, 32'h0);
        slv_cyc(1'b0, 24'h40_0040, 6'h39, 16'h0, rd, ok, ack_at);
        chk("R8 read after write is first half", {16'd0, rd}, {16'd0, rmem({off, 20'h00040})} >> 16);
        chk("R8 read ran master", mcount, mc + 1);
        slv_cyc(1'b1, 24'h40_0080, 6'h39, 16'hBBBB, rd, ok, ack_at);
        chk("R8 write after read is first half", mcount, mc + 1);
        expect_m({off, 20'h00080}, 1'b1, 32'hBBBB_CCCC);
        slv_cyc(1'b1, 24'h40_0082, 6'h39, 16'hCCCC, rd, ok, ack_at);
        chk("R8 write pair completes", mcount, mc + 2);

        // R10: ack pulse is single and a held request is not re-accepted
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_addr = 24'h50_0000 >> 1; s_am = 6'h39; s_wdata = 16'h4560;
        repeat (3) @(negedge clk);
        chk("R10 ack not repeated while req held", {31'd0, s_ack}, 0);
        s_req = 1'b0;
        repeat (2) @(negedge clk);

        repeat (4) @(negedge clk);
        chk("scoreboard empty", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule